// File: doc/BRIEF.md
# Transition-Activity Loss-of-Signal Detector

This block watches a recovered serial NRZ stream that arrives as one sampled bit per unit interval (UI), marked by a bit-valid strobe. It declares loss of signal when the line stops toggling for a programmable number of UIs. It withdraws that declaration only after the line shows enough activity inside a short sliding window, which gives the flag hysteresis. The set rule is a long absolute timeout. The clear rule is a transition-density count.

While the flag is raised, the registered receive data output is forced to zero. The receive clock phase selection that the block passes through is frozen at its last value, so the downstream clock stays stable. Two mode inputs, local loopback and receive monitor, each switch detection off. While either is active the flag is held low and the detection history starts afresh.

The default timeout is 358 UI, which is roughly 2.3 microseconds at 155.52 Mb/s. The default window is 32 UI, and the default clear threshold is 5 transitions.

Top module: `los_activity_det`

## Requirements
- R1: With no mode input active and the flag low, the flag `los_o` rises at the clock edge that takes the SILENCE_UI-th (default 358) consecutive valid UI without a transition. After SILENCE_UI-1 such UIs it is still low.
- R2: With the flag high, it falls at the clock edge that takes a valid UI which brings the number of transitions among the last WIN_UI (32) valid UIs to at least CLR_MIN (5).
- R3: With exactly 4 transitions in every 32-UI window (a toggle every 8 UI), a raised flag stays high. A flag that is low also stays low under that pattern, because no silent run reaches SILENCE_UI.
- R4: Whenever the flag is high, `dout` is 0.
- R5: While the flag is high, `ph_out` holds its value. While the flag is low, `ph_out` equals `ph_in` as it was at the previous clock edge.
- R6: While `lpbk_en` or `mon_en` is 1, the flag goes low at the next clock edge and stays low. The silence count and the window restart from empty, so after the mode ends a further SILENCE_UI silent UIs are needed to raise the flag.
- R7: After synchronous reset, `los_o`=1, `dout`=0, `dout_vld`=0 and `ph_out`=0.
- R8: Cycles with `bit_vld`=0 do not count as UIs. Their `bit_in` value affects neither the transition history nor the silence count.
- R9: A transition is a valid bit that differs from the previous valid bit. The reference value after reset is 0, so a first valid bit of 1 counts as a transition.
- R10: When the flag is low, `dout` takes the `bit_in` of the valid UI one clock later. `dout_vld` is `bit_vld` delayed by one clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Receive-side clock |
| rst | input | 1 | Synchronous active-high reset |
| bit_in | input | 1 | Sampled NRZ data bit |
| bit_vld | input | 1 | Marks a cycle that carries one UI |
| lpbk_en | input | 1 | Local loopback mode; disables detection |
| mon_en | input | 1 | Receive monitor mode; disables detection |
| ph_in | input | PH_W | Clock phase selection from the recovery loop |
| los_o | output | 1 | Loss-of-signal flag |
| dout | output | 1 | Registered receive data, zero while the flag is high |
| dout_vld | output | 1 | Valid strobe for `dout` |
| ph_out | output | PH_W | Phase selection, frozen while the flag is high |

## Verification
The assertions check four properties on every cycle:
- data is squelched whenever the flag is high;
- the phase output is frozen during loss;
- either mode input drops the flag on the next edge;
- the flag only rises or falls at an edge that took a valid UI, or when a mode releases it.

The bench scenarios cover what a single-cycle property cannot. These are the exact 357/358 timeout boundary, the 4-versus-5 transitions-in-32-UI hysteresis, slow toggling that keeps a clear line clear, and the rule that non-valid cycles and the reset reference bit shape the transition count.

// File: rtl/los_pkg.sv
package los_pkg;
  localparam int unsigned DEF_SILENCE_UI = 358;
  localparam int unsigned DEF_WIN_UI     = 32;
  localparam int unsigned DEF_CLR_MIN    = 5;
  localparam int unsigned DEF_PH_W       = 3;

  typedef enum logic {
    LINE_OK   = 1'b0,
    LINE_LOST = 1'b1
  } line_state_e;
endpackage

// File: rtl/los_edge_det.sv
module los_edge_det (
  input  logic clk,
  input  logic rst,
  input  logic bit_in,
  input  logic bit_vld,
  output logic trans
);
  logic prev_q;

  // Reference bit follows valid UIs only; reset reference is 0.
  always_ff @(posedge clk) begin
    if (rst)          prev_q <= 1'b0;
    else if (bit_vld) prev_q <= bit_in;
  end

  assign trans = bit_vld & (bit_in ^ prev_q);
endmodule

// File: rtl/los_silence_timer.sv
module los_silence_timer #(
  parameter int unsigned SILENCE_UI = 358,
  localparam int unsigned CW = $clog2(SILENCE_UI + 1)
) (
  input  logic clk,
  input  logic rst,
  input  logic clr,
  input  logic bit_vld,
  input  logic trans,
  output logic expired
);
  localparam logic [CW-1:0] LIMIT = CW'(SILENCE_UI);

  logic [CW-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (clr)                          cnt_d = '0;
    else if (trans)                   cnt_d = '0;
    else if (bit_vld && cnt_q != LIMIT) cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) cnt_q <= '0;
    else     cnt_q <= cnt_d;
  end

  // Evaluated on the next count so the flag moves with the UI edge.
  assign expired = (cnt_d == LIMIT);
endmodule

// File: rtl/los_density_win.sv
module los_density_win #(
  parameter int unsigned WIN_UI  = 32,
  parameter int unsigned CLR_MIN = 5,
  localparam int unsigned PW = $clog2(WIN_UI + 1)
) (
  input  logic clk,
  input  logic rst,
  input  logic clr,
  input  logic bit_vld,
  input  logic trans,
  output logic dense
);
  logic [WIN_UI-1:0] win_q, win_d;
  logic [PW-1:0]     pop;

  always_comb begin
    win_d = win_q;
    if (clr)          win_d = '0;
    else if (bit_vld) win_d = {win_q[WIN_UI-2:0], trans};
  end

  always_ff @(posedge clk) begin
    if (rst) win_q <= '0;
    else     win_q <= win_d;
  end

  always_comb begin
    pop = '0;
    for (int i = 0; i < int'(WIN_UI); i++) pop = pop + PW'(win_d[i]);
  end

  assign dense = (pop >= PW'(CLR_MIN));
endmodule

// File: rtl/los_out_stage.sv
module los_out_stage #(
  parameter int unsigned PH_W = 3
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            lost_d,
  input  logic            bit_in,
  input  logic            bit_vld,
  input  logic [PH_W-1:0] ph_in,
  output logic            dout,
  output logic            dout_vld,
  output logic [PH_W-1:0] ph_out
);
  always_ff @(posedge clk) begin
    if (rst) begin
      dout     <= 1'b0;
      dout_vld <= 1'b0;
      ph_out   <= '0;
    end else begin
      dout_vld <= bit_vld;
      if (lost_d)       dout <= 1'b0;
      else if (bit_vld) dout <= bit_in;
      if (!lost_d)      ph_out <= ph_in;
    end
  end
endmodule

// File: rtl/los_activity_det.sv
module los_activity_det
  import los_pkg::*;
#(
  parameter int unsigned SILENCE_UI = DEF_SILENCE_UI,
  parameter int unsigned WIN_UI     = DEF_WIN_UI,
  parameter int unsigned CLR_MIN    = DEF_CLR_MIN,
  parameter int unsigned PH_W       = DEF_PH_W
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            bit_in,
  input  logic            bit_vld,
  input  logic            lpbk_en,
  input  logic            mon_en,
  input  logic [PH_W-1:0] ph_in,
  output logic            los_o,
  output logic            dout,
  output logic            dout_vld,
  output logic [PH_W-1:0] ph_out
);
  logic        trans, expired, dense, mode_off;
  line_state_e st_q, st_d;

  assign mode_off = lpbk_en | mon_en;

  los_edge_det u_edge (
    .clk(clk), .rst(rst), .bit_in(bit_in), .bit_vld(bit_vld), .trans(trans)
  );

  los_silence_timer #(.SILENCE_UI(SILENCE_UI)) u_timer (
    .clk(clk), .rst(rst), .clr(mode_off), .bit_vld(bit_vld),
    .trans(trans), .expired(expired)
  );

  los_density_win #(.WIN_UI(WIN_UI), .CLR_MIN(CLR_MIN)) u_win (
    .clk(clk), .rst(rst), .clr(mode_off), .bit_vld(bit_vld),
    .trans(trans), .dense(dense)
  );

  always_comb begin
    st_d = st_q;
    if (mode_off) st_d = LINE_OK;
    else begin
      case (st_q)
        LINE_OK:   if (expired) st_d = LINE_LOST;
        LINE_LOST: if (dense)   st_d = LINE_OK;
        default:   st_d = LINE_LOST;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) st_q <= LINE_LOST;
    else     st_q <= st_d;
  end

  assign los_o = (st_q == LINE_LOST);

  los_out_stage #(.PH_W(PH_W)) u_out (
    .clk(clk), .rst(rst), .lost_d(st_d == LINE_LOST), .bit_in(bit_in),
    .bit_vld(bit_vld), .ph_in(ph_in), .dout(dout), .dout_vld(dout_vld),
    .ph_out(ph_out)
  );
endmodule

// File: rtl/los_activity_det_chk.sv
module los_activity_det_chk #(
  parameter int unsigned PH_W = 3
) (
  input logic            clk,
  input logic            rst,
  input logic            bit_in,
  input logic            bit_vld,
  input logic            lpbk_en,
  input logic            mon_en,
  input logic [PH_W-1:0] ph_in,
  input logic            los_o,
  input logic            dout,
  input logic            dout_vld,
  input logic [PH_W-1:0] ph_out
);
  p_squelch_r4: assert property (@(posedge clk) disable iff (rst)
    los_o |-> (dout == 1'b0));

  p_phase_frozen_r5: assert property (@(posedge clk) disable iff (rst)
    los_o |-> $stable(ph_out));

  p_mode_drops_r6: assert property (@(posedge clk) disable iff (rst)
    (lpbk_en || mon_en) |=> !los_o);

  p_rise_on_ui_r1: assert property (@(posedge clk) disable iff (rst)
    $rose(los_o) |-> ($past(bit_vld) && !$past(lpbk_en) && !$past(mon_en)));

  p_fall_cause_r2: assert property (@(posedge clk) disable iff (rst)
    $fell(los_o) |-> ($past(bit_vld) || $past(lpbk_en) || $past(mon_en)));
endmodule

bind los_activity_det los_activity_det_chk #(.PH_W(PH_W)) u_chk (.*);

// File: tb/los_activity_det_tb.sv
module los_activity_det_tb;
  localparam int PH_W = 3;
  localparam int SIL  = 358;

  logic clk = 1'b0, rst = 1'b1;
  logic bit_in = 1'b0, bit_vld = 1'b0, lpbk_en = 1'b0, mon_en = 1'b0;
  logic [PH_W-1:0] ph_in = '0;
  logic los_o, dout, dout_vld;
  logic [PH_W-1:0] ph_out;
  int n_run = 0, n_fail = 0;
  logic cur = 1'b0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  los_activity_det u_dut (
    .clk(clk), .rst(rst), .bit_in(bit_in), .bit_vld(bit_vld),
    .lpbk_en(lpbk_en), .mon_en(mon_en), .ph_in(ph_in), .los_o(los_o),
    .dout(dout), .dout_vld(dout_vld), .ph_out(ph_out)
  );

  // {toggle spacing (0 = constant line), UIs driven, expected flag}
  localparam int unsigned TBL [0:7][0:2] = '{
    '{8, 200, 1},   // R3: 4 per 32 UI cannot clear
    '{7,  64, 0},   // R2: 5 per 32 UI clears
    '{8, 200, 0},   // R3: slow toggle keeps clear line clear
    '{0, 400, 1},   // R1: silent line
    '{6,  64, 0},   // R2
    '{0, 400, 1},   // R1
    '{16, 200, 1},  // R3: sparse toggling
    '{1,  40, 0}    // R2: dense toggling
  };

  task automatic chk(input string req, input int act, input int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic send(input logic b);
    bit_in  = b;
    bit_vld = 1'b1;
    ph_in   = ph_in + 1'b1;
    @(posedge clk); #1;
    bit_vld = 1'b0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      bit_in = ~bit_in;
      ph_in  = ph_in + 1'b1;
      @(posedge clk); #1;
    end
  endtask

  task automatic do_reset();
    rst = 1'b1; bit_vld = 1'b0; cur = 1'b0;
    repeat (2) @(posedge clk);
    #1 rst = 1'b0;
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_run++; n_fail++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    logic [PH_W-1:0] ph_seen;
    logic            sq_bad;
    do_reset();
    @(posedge clk); #1;
    // R7: reset values
    chk("R7 los", los_o, 1);
    chk("R7 dout", dout, 0);
    chk("R7 dout_vld", dout_vld, 0);
    chk("R7 ph_out", ph_out, 0);

    // Table walk
    for (int v = 0; v < 8; v++) begin
      sq_bad = 1'b0;
      for (int i = 0; i < int'(TBL[v][1]); i++) begin
        if (TBL[v][0] != 0 && (i % TBL[v][0]) == TBL[v][0] - 1) cur = ~cur;
        send(cur);
        if (los_o && dout) sq_bad = 1'b1;
      end
      chk($sformatf("R1/R2/R3 vec%0d", v), los_o, TBL[v][2]);
      chk($sformatf("R4 vec%0d squelch", v), sq_bad, 0);
    end

    // R10: data passes with one-cycle delay while clear
    send(~cur); cur = ~cur;
    chk("R10 dout", dout, cur);
    chk("R10 dout_vld", dout_vld, 1);
    @(posedge clk); #1;
    chk("R10 dout_vld low", dout_vld, 0);
    // R5: phase follows previous-edge input while clear
    ph_seen = ph_in; ph_in = ph_in + 3'd3;
    @(posedge clk); #1;
    chk("R5 ph follows", ph_out, ph_seen + 3'd3);

    // R1 boundary: one transition then 357 silent UIs, then one more
    send(~cur); cur = ~cur;
    for (int i = 0; i < SIL - 1; i++) send(cur);
    chk("R1 at 357", los_o, 0);
    send(cur);
    chk("R1 at 358", los_o, 1);
    // R4: a 1 on the line is squelched while lost
    send(1'b1); cur = 1'b1;
    chk("R4 dout zero", dout, 0);
    // R5: phase frozen while lost
    ph_seen = ph_out;
    idle(5);
    chk("R5 ph frozen", ph_out, ph_seen);

    // R6: loopback drops the flag and restarts the silence count
    lpbk_en = 1'b1;
    @(posedge clk); #1;
    chk("R6 lpbk drop", los_o, 0);
    for (int i = 0; i < 500; i++) send(cur);
    chk("R6 lpbk held", los_o, 0);
    lpbk_en = 1'b0;
    for (int i = 0; i < SIL - 1; i++) send(cur);
    chk("R6 restart 357", los_o, 0);
    send(cur);
    chk("R6 restart 358", los_o, 1);
    mon_en = 1'b1;
    @(posedge clk); #1;
    chk("R6 mon drop", los_o, 0);
    send(1'b1);
    chk("R6 mon data passes", dout, 1);
    mon_en = 1'b0;

    // R9 / R2 exact: after reset, 1,0,1,0 gives 4 transitions, next 1 gives 5
    do_reset();
    send(1); send(0); send(1); send(0);
    chk("R9 four transitions", los_o, 1);
    send(1);
    chk("R9 fifth clears", los_o, 0);

    // R8: non-valid cycles are ignored
    do_reset();
    send(1);
    idle(21);
    chk("R8 idle ignored", los_o, 1);
    send(0); send(1); send(0);
    chk("R8 four counted", los_o, 1);
    send(1);
    chk("R8 fifth clears", los_o, 0);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule